// File: doc/BRIEF.md
# Stepped Soft-Start Ramp Generator

This block produces the digital reference ramp that brings a two-channel power-supply controller up from zero. It runs on the switching-oscillator clock. A prescaler divides that clock into a slow step clock, and each step raises a shared reference code by one unit. Both regulator channels follow the same code, so neither channel has its own rate or order. A short initialization phase runs after every start so that the ramp always begins at zero. The ramp then climbs through its steps and holds at full scale.

Two milestones come out of the block. The quarter flag marks the point where fault comparators may be armed. The done flag marks the end of the ramp. For each channel, a digital comparator input reports whether that channel's output is still above the live ramp. While it is, the channel's power-stage enable stays low. The enable is released once the ramp overtakes the output. If the output never falls below the ramp, the enable is released only when the ramp completes.

Top module: `softstart_ramp`

## Requirements
- R1: After reset, ref_code is 0, and quarter, done, active and every gate_en bit are low.
- R2: A start pulse sampled at clock edge E0 sets active. The block then spends INIT_CYCLES (default 4) clocks in initialization with ref_code at 0. After edge E0+INIT_CYCLES+64*k, ref_code equals k, for k from 0 to 64.
- R3: ref_code changes only by rising by exactly 1, once every PRESCALE (default 64) clocks, or by returning to 0. It never exceeds STEPS (default 64).
- R4: done rises in the same cycle that ref_code reaches 64, which is 4096+INIT_CYCLES clocks after the start edge. ref_code then holds 64 and done stays high until the next start or abort.
- R5: quarter is high exactly while ref_code is 16 or more, that is one quarter of full scale.
- R6: An abort sampled at an edge returns ref_code to 0 and clears quarter, done, active and all gate_en bits after that edge. Abort takes priority over a start in the same cycle.
- R7: A start pulse during a ramp or after completion restarts the whole sequence identically, with the same initialization and step timing as the first start.
- R8: During the stepping phase, gate_en[i] rises one clock after the edge that samples above_ramp[i] low. It then stays high, whatever above_ramp[i] does, until the next start or abort.
- R9: If above_ramp[i] stays high for the whole ramp (output pre-charged above final), gate_en[i] stays low until done rises and goes high in the same cycle as done.
- R10: above_ramp is ignored while idle and during initialization. A low value there does not raise gate_en.
- R11: The channels gate independently of each other while sharing the single ref_code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Switching-oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin or restart the ramp (one-clock pulse) |
| abort | input | 1 | Stop and clear the ramp |
| above_ramp | input | CH | Per channel: the sensed output is above the present ramp level |
| ref_code | output | $clog2(STEPS)+1 | Shared reference code, 0 to STEPS |
| quarter | output | 1 | Ramp is at or past one quarter of full scale |
| done | output | 1 | Ramp is at full scale |
| active | output | 1 | A ramp sequence is in progress or complete |
| gate_en | output | CH | Per-channel power-stage enable |

## Verification
A wrong prescaler or step count shows up on ref_code within one step, that is 64 clocks, as an early or late increment. The bench samples ref_code at the exact edges just before and after the expected changes, so an error of a single clock is caught. A broken initialization count shifts every later sample and is seen at the first step boundary. Faults in the per-channel release latch show up on gate_en one clock after the comparator changes, or at the done edge for a channel whose output stays high. A faulty abort or restart path leaves a nonzero code or a lingering flag on the first sample after the pulse.

// File: rtl/softstart_ramp.sv
module softstart_ramp #(
  parameter int CH          = 2,
  parameter int STEPS       = 64,
  parameter int PRESCALE    = 64,
  parameter int INIT_CYCLES = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       abort,
  input  logic [CH-1:0]              above_ramp,
  output logic [$clog2(STEPS):0]     ref_code,
  output logic                       quarter,
  output logic                       done,
  output logic                       active,
  output logic [CH-1:0]              gate_en
);
  localparam int CW = $clog2(STEPS) + 1;
  localparam int PW = $clog2(PRESCALE);
  localparam int IW = $clog2(INIT_CYCLES + 1);

  typedef enum logic [1:0] {S_IDLE, S_INIT, S_RAMP, S_DONE} st_t;

  st_t           st;
  logic [CW-1:0] code;
  logic [PW-1:0] pre;
  logic [IW-1:0] icnt;
  logic [CH-1:0] rel;

  wire step_tick = (pre == PW'(PRESCALE - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      code <= '0;
      pre  <= '0;
      icnt <= '0;
      rel  <= '0;
    end else if (abort || start) begin
      st   <= abort ? S_IDLE : S_INIT;
      code <= '0;
      pre  <= '0;
      icnt <= '0;
      rel  <= '0;
    end else begin
      case (st)
        S_INIT: begin
          if (icnt == IW'(INIT_CYCLES - 1)) st <= S_RAMP;
          else icnt <= icnt + 1'b1;
        end
        S_RAMP: begin
          rel <= rel | ~above_ramp;
          if (step_tick) begin
            pre  <= '0;
            code <= code + 1'b1;
            if (code == CW'(STEPS - 1)) st <= S_DONE;
          end else begin
            pre <= pre + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign ref_code = code;
  assign quarter  = (code >= CW'(STEPS / 4));
  assign done     = (st == S_DONE);
  assign active   = (st != S_IDLE);
  assign gate_en  = rel | {CH{done}};
endmodule

// File: rtl/softstart_ramp_chk.sv
module softstart_ramp_chk #(
  parameter int CH    = 2,
  parameter int STEPS = 64
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start,
  input logic                   abort,
  input logic [$clog2(STEPS):0] ref_code,
  input logic                   quarter,
  input logic                   done,
  input logic                   active,
  input logic [CH-1:0]          gate_en
);
  localparam int CW = $clog2(STEPS) + 1;

  a_r3_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_code != $past(ref_code)) |-> (ref_code == $past(ref_code) + CW'(1) || ref_code == '0));

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    ref_code <= CW'(STEPS));

  a_r4_done_full: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ref_code == CW'(STEPS) && active));

  a_r5_quarter_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(quarter) |-> ref_code == CW'(STEPS / 4));

  a_r6_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (ref_code == '0 && !done && !active && gate_en == '0));

  a_r8_gate_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !abort) |=> ((gate_en & $past(gate_en)) == $past(gate_en)));

  a_r10_gate_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> gate_en == '0);
endmodule

bind softstart_ramp softstart_ramp_chk #(.CH(CH), .STEPS(STEPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .ref_code(ref_code),
  .quarter(quarter), .done(done), .active(active), .gate_en(gate_en)
);

// File: tb/sim_softstart_ramp.sv
module sim_softstart_ramp;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       abort = 1'b0;
  logic [1:0] above_ramp = 2'b00;
  logic [6:0] ref_code;
  logic       quarter, done, active;
  logic [1:0] gate_en;

  int errors = 0;
  int checks = 0;
  int c = 0;

  always #10 clk = ~clk;

  softstart_ramp u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .above_ramp(above_ramp),
    .ref_code(ref_code), .quarter(quarter), .done(done), .active(active), .gate_en(gate_en)
  );

  // cycles after start edge, expected code, quarter, done, gate (ch0 held above ramp, ch1 low)
  localparam int N = 12;
  localparam int        TC [N] = '{0, 3, 4, 5, 67, 68, 1027, 1028, 2116, 4099, 4100, 4200};
  localparam int        TK [N] = '{0, 0, 0, 0, 0,  1,  15,   16,   33,   63,   64,   64};
  localparam logic      TQ [N] = '{0, 0, 0, 0, 0,  0,  0,    1,    1,    1,    1,    1};
  localparam logic      TD [N] = '{0, 0, 0, 0, 0,  0,  0,    0,    0,    0,    1,    1};
  localparam logic [1:0] TG [N] = '{2'b00, 2'b00, 2'b00, 2'b10, 2'b10, 2'b10, 2'b10,
                                    2'b10, 2'b10, 2'b10, 2'b11, 2'b11};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, c, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    c++;
  endtask

  task automatic kick();
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    c = 0;
  endtask

  task automatic go_to(input int n);
    while (c < n) tick();
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 code", ref_code, 0);
    chk("R1 flags", {quarter, done, active}, 0);
    chk("R1 gate", gate_en, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: comparator low while idle raises nothing
    above_ramp = 2'b00;
    tick();
    chk("R10 idle gate", gate_en, 0);

    // main ramp: R2 R3 R4 R5 R9 R10 R11
    above_ramp = 2'b10;
    above_ramp = 2'b01;  // ch0 stays above ramp, ch1 below (R11)
    kick();
    chk("R2 active", active, 1);
    for (int i = 0; i < N; i++) begin
      go_to(TC[i]);
      chk("R2/R3 code", ref_code, TK[i]);
      chk("R5 quarter", quarter, TQ[i]);
      chk("R4 done", done, TD[i]);
      chk("R8/R9/R10/R11 gate", gate_en, TG[i]);
    end

    // R7 restart after completion, pre-charged below final on ch0 (R8)
    above_ramp = 2'b11;
    kick();
    chk("R7 code restart", ref_code, 0);
    chk("R7 done cleared", done, 0);
    chk("R7 gate cleared", gate_en, 0);
    go_to(67);
    chk("R7 code before step", ref_code, 0);
    tick();
    chk("R7 code at step", ref_code, 1);
    go_to(600);
    chk("R8 gate before", gate_en, 0);
    above_ramp = 2'b10;
    tick();
    chk("R8 gate after one clock", gate_en, 2'b01);
    above_ramp = 2'b11;
    go_to(700);
    chk("R8 gate sticky", gate_en, 2'b01);

    // R7 restart mid-ramp
    kick();
    go_to(68);
    chk("R7 mid-ramp restart timing", ref_code, 1);

    // R6 abort mid-ramp
    go_to(1500);
    abort = 1'b1;
    tick();
    abort = 1'b0;
    chk("R6 code", ref_code, 0);
    chk("R6 flags", {quarter, done, active}, 0);
    chk("R6 gate", gate_en, 0);
    above_ramp = 2'b00;
    go_to(1520);
    chk("R6 stays idle", ref_code, 0);
    chk("R10 gate after abort", gate_en, 0);

    // R6 abort wins over start
    abort = 1'b1;
    start = 1'b1;
    tick();
    abort = 1'b0;
    start = 1'b0;
    go_to(1530);
    chk("R6 priority active", active, 0);
    chk("R6 priority code", ref_code, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule